// File: doc/BRIEF.md
# Broadcast Configuration Latch Bank

This block holds the configuration of a four-channel serial receiver as a bank of 8-bit latches. Each channel has two static latches, which set its line rate, training rate and data-select fields, and one dynamic latch, which controls its output drivers, PLL power-down and receive mode. A host loads the bank one byte at a time through a 4-bit address, an 8-bit data bus and a write strobe. Each write takes effect on the clock edge where the strobe is high.

Three further addresses broadcast a byte to one latch type in every channel at once. A channel takes part only if bit 0 of its own target latch is set. Bit 0 of the broadcast byte forces every channel to take part, whatever its own bit 0 holds. A separate mask latch limits which bits a broadcast may change. Bit 0 of a latch is never changed by a broadcast.

The decoded fields come out as per-channel vectors, together with a power-down flag for each channel whose two output drivers are both off. The raw latch contents are also brought out so that they can be read back.

Top module: `bcfg_bcast_bank`

## Requirements
- R1: While rst_n is low, on each clock edge every first static latch returns to 0xBF, every second static latch to 0xAD, every dynamic latch to 0xB3 and the mask to 0xFF. As a result, every output-driver enable is 0.
- R2: A write with wr_en high to an address a below 12 loads all 8 data bits into channel a/3 on that clock edge. Channel 0 is A and channel 3 is D. The latch is chosen by a%3: 0 is the first static latch, 1 the second static latch and 2 the dynamic latch.
- R3: While wr_en is low, no latch and no mask changes, whatever the address and data inputs carry.
- R4: A write to address 12, 13 or 14 is a broadcast to the first static, second static or dynamic latch of every channel. A latch whose bit 0 is 1 takes part. A latch whose bit 0 is 0 keeps its value when the broadcast byte has bit 0 = 0.
- R5: When bit 0 of a broadcast byte is 1, the matching latch of every channel takes part, including latches whose bit 0 is 0.
- R6: A participating latch takes from the broadcast byte only bits 7:1 whose mask bit is 1, and keeps its other bits. Its bit 0 is never changed by a broadcast.
- R7: A write to address 15 loads the mask. The mask has no effect on direct writes to addresses 0 to 11.
- R8: Dynamic latch decode: bit 2 is drv_pri_en and bit 3 is drv_sec_en. Bit 6 is pll_pd. rx_mode for channel c sits at [2c+1:2c] as {bit 7, bit 5}, where 01 selects video-stream reception and 10 selects self-test pattern reception.
- R9: Static latch decode: bit 1 of the first static latch is rx_rate. Bit 1 of the second static latch is trn_rate. For channel c, bits 5:4 of the second static latch appear on dsel1[2c+1:2c] and bits 7:6 on dsel2[2c+1:2c].
- R10: chan_pd[c] is 1 exactly when drv_pri_en[c] and drv_sec_en[c] are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Latch address |
| wr_data | input | 8 | Write data |
| drv_pri_en | output | 4 | Primary output-driver enable per channel |
| drv_sec_en | output | 4 | Secondary output-driver enable per channel |
| pll_pd | output | 4 | Receive PLL power-down per channel |
| rx_mode | output | 8 | Two-bit receive mode per channel |
| rx_rate | output | 4 | Receive rate select per channel |
| trn_rate | output | 4 | Training rate select per channel |
| dsel1 | output | 8 | First two-bit data select per channel |
| dsel2 | output | 8 | Second two-bit data select per channel |
| chan_pd | output | 4 | Channel logic power-down flag |
| st0_rb | output | 32 | First static latches, channel c at [8c+7:8c] |
| st1_rb | output | 32 | Second static latches, channel c at [8c+7:8c] |
| dyn_rb | output | 32 | Dynamic latches, channel c at [8c+7:8c] |
| mask_rb | output | 8 | Broadcast mask |

## Verification
The assertions check every cycle that:
- the decoded write selects stay one-hot;
- a direct write lands exactly;
- an idle cycle leaves each latch alone;
- a gated-off latch ignores an unforced broadcast;
- a broadcast never touches masked bits or bit 0;
- reset restores each default.

Some behaviours only the bench's scenarios can show. These are whether the right channel and latch type are chosen for each address, the combined effect of force, gating and mask on a full set of channels, and the mask's lack of effect on direct writes. The same holds for the field decode and the power-down flag, which the bench follows through driver enables switching on and off.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;
    localparam int DW         = 8;
    localparam int LAT_PER_CH = 3;
    localparam int N_GLB      = 3;

    localparam logic [DW-1:0] ST0_RST  = 8'hBF;
    localparam logic [DW-1:0] ST1_RST  = 8'hAD;
    localparam logic [DW-1:0] DYN_RST  = 8'hB3;
    localparam logic [DW-1:0] MASK_RST = 8'hFF;

    localparam int GEN_BIT   = 0;
    localparam int RATE_BIT  = 1;
    localparam int PRI_BIT   = 2;
    localparam int SEC_BIT   = 3;
    localparam int PLLPD_BIT = 6;
    localparam int MODE_HI   = 7;
    localparam int MODE_LO   = 5;

    localparam int LT_ST0 = 0;
    localparam int LT_ST1 = 1;
    localparam int LT_DYN = 2;

    typedef logic [DW-1:0] byte_t;

    typedef struct packed {
        logic [LAT_PER_CH-1:0][DW-1:0] lat;
    } chan_lat_t;

    function automatic byte_t lat_reset(input int kind);
        case (kind)
            LT_ST0:  return ST0_RST;
            LT_ST1:  return ST1_RST;
            default: return DYN_RST;
        endcase
    endfunction

    function automatic byte_t bcast_merge(input byte_t old_v, input byte_t data,
                                          input byte_t mask);
        byte_t upd;
        upd = mask & ~(byte_t'(1) << GEN_BIT);
        if (!(old_v[GEN_BIT] || data[GEN_BIT]))
            return old_v;
        return (old_v & ~upd) | (data & upd);
    endfunction
endpackage

// File: rtl/bcfg_decode.sv
module bcfg_decode #(
    parameter int N_CH = 4,
    parameter int AW   = 4
) (
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    output logic [N_CH*bcfg_pkg::LAT_PER_CH-1:0] dir_we,
    output logic [bcfg_pkg::N_GLB-1:0]  bc_we,
    output logic                        mask_we
);
    import bcfg_pkg::*;

    localparam int N_DIR     = N_CH * LAT_PER_CH;
    localparam int BC_BASE   = N_DIR;
    localparam int MASK_ADDR = N_DIR + N_GLB;

    for (genvar i = 0; i < N_DIR; i++) begin : g_dir
        assign dir_we[i] = wr_en && (wr_addr == AW'(i));
    end

    for (genvar j = 0; j < N_GLB; j++) begin : g_bc
        assign bc_we[j] = wr_en && (wr_addr == AW'(BC_BASE + j));
    end

    assign mask_we = wr_en && (wr_addr == AW'(MASK_ADDR));

    always_comb begin
        if (!$isunknown({dir_we, bc_we, mask_we}))
            a_r2_onehot_select: assert ($onehot0({dir_we, bc_we, mask_we}));
    end
endmodule

// File: rtl/bcfg_mask.sv
module bcfg_mask (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mask_we,
    input  logic [bcfg_pkg::DW-1:0] wr_data,
    output logic [bcfg_pkg::DW-1:0] mask_q
);
    import bcfg_pkg::*;

    byte_t mask_d;

    always_comb begin
        mask_d = mask_q;
        if (mask_we)
            mask_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RST;
        else
            mask_q <= mask_d;
    end

    a_r7_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(wr_data)));
    a_r1_mask_reset: assert property (@(posedge clk)
        !rst_n |=> (mask_q == MASK_RST));
endmodule

// File: rtl/bcfg_chan.sv
module bcfg_chan (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [bcfg_pkg::LAT_PER_CH-1:0] dir_we,
    input  logic [bcfg_pkg::N_GLB-1:0]      bc_we,
    input  logic [bcfg_pkg::DW-1:0]         wr_data,
    input  logic [bcfg_pkg::DW-1:0]         mask,
    output bcfg_pkg::chan_lat_t             lat_q
);
    import bcfg_pkg::*;

    chan_lat_t lat_d;

    always_comb begin
        lat_d = lat_q;
        for (int k = 0; k < LAT_PER_CH; k++) begin
            if (dir_we[k])
                lat_d.lat[k] = wr_data;
            else if (bc_we[k])
                lat_d.lat[k] = bcast_merge(lat_q.lat[k], wr_data, mask);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT_PER_CH; k++)
                lat_q.lat[k] <= lat_reset(k);
        end else begin
            lat_q <= lat_d;
        end
    end

    for (genvar k = 0; k < LAT_PER_CH; k++) begin : g_chk
        a_r1_reset_value: assert property (@(posedge clk)
            !rst_n |=> (lat_q.lat[k] == lat_reset(k)));
        a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
            dir_we[k] |=> (lat_q.lat[k] == $past(wr_data)));
        a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(dir_we[k] || bc_we[k]) |=> $stable(lat_q.lat[k]));
        a_r4_gate_block: assert property (@(posedge clk) disable iff (!rst_n)
            (bc_we[k] && !lat_q.lat[k][GEN_BIT] && !wr_data[GEN_BIT])
            |=> $stable(lat_q.lat[k]));
        a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
            bc_we[k] |=> ((((lat_q.lat[k] ^ $past(lat_q.lat[k])) & ~$past(mask))
                           & 8'hFE) == 8'h00));
        a_r6_gen_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
            bc_we[k] |=> (lat_q.lat[k][GEN_BIT] == $past(lat_q.lat[k][GEN_BIT])));
    end
endmodule

// File: rtl/bcfg_bcast_bank.sv
module bcfg_bcast_bank #(
    parameter int N_CH = 4,
    localparam int AW  = $clog2(N_CH * bcfg_pkg::LAT_PER_CH + bcfg_pkg::N_GLB + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [bcfg_pkg::DW-1:0]      wr_data,
    output logic [N_CH-1:0]              drv_pri_en,
    output logic [N_CH-1:0]              drv_sec_en,
    output logic [N_CH-1:0]              pll_pd,
    output logic [2*N_CH-1:0]            rx_mode,
    output logic [N_CH-1:0]              rx_rate,
    output logic [N_CH-1:0]              trn_rate,
    output logic [2*N_CH-1:0]            dsel1,
    output logic [2*N_CH-1:0]            dsel2,
    output logic [N_CH-1:0]              chan_pd,
    output logic [N_CH*bcfg_pkg::DW-1:0] st0_rb,
    output logic [N_CH*bcfg_pkg::DW-1:0] st1_rb,
    output logic [N_CH*bcfg_pkg::DW-1:0] dyn_rb,
    output logic [bcfg_pkg::DW-1:0]      mask_rb
);
    import bcfg_pkg::*;

    localparam int N_DIR = N_CH * LAT_PER_CH;

    logic [N_DIR-1:0] dir_we;
    logic [N_GLB-1:0] bc_we;
    logic             mask_we;
    byte_t            mask_q;
    chan_lat_t        ch_lat [N_CH];

    bcfg_decode #(.N_CH(N_CH), .AW(AW)) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .dir_we  (dir_we),
        .bc_we   (bc_we),
        .mask_we (mask_we)
    );

    bcfg_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .wr_data (wr_data),
        .mask_q  (mask_q)
    );

    assign mask_rb = mask_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        bcfg_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .dir_we  (dir_we[c*LAT_PER_CH +: LAT_PER_CH]),
            .bc_we   (bc_we),
            .wr_data (wr_data),
            .mask    (mask_q),
            .lat_q   (ch_lat[c])
        );

        assign st0_rb[c*DW +: DW] = ch_lat[c].lat[LT_ST0];
        assign st1_rb[c*DW +: DW] = ch_lat[c].lat[LT_ST1];
        assign dyn_rb[c*DW +: DW] = ch_lat[c].lat[LT_DYN];

        assign drv_pri_en[c]   = ch_lat[c].lat[LT_DYN][PRI_BIT];
        assign drv_sec_en[c]   = ch_lat[c].lat[LT_DYN][SEC_BIT];
        assign pll_pd[c]       = ch_lat[c].lat[LT_DYN][PLLPD_BIT];
        assign rx_mode[2*c +: 2] = {ch_lat[c].lat[LT_DYN][MODE_HI],
                                    ch_lat[c].lat[LT_DYN][MODE_LO]};
        assign rx_rate[c]      = ch_lat[c].lat[LT_ST0][RATE_BIT];
        assign trn_rate[c]     = ch_lat[c].lat[LT_ST1][RATE_BIT];
        assign dsel1[2*c +: 2] = ch_lat[c].lat[LT_ST1][5:4];
        assign dsel2[2*c +: 2] = ch_lat[c].lat[LT_ST1][7:6];
        assign chan_pd[c]      = ~(drv_pri_en[c] | drv_sec_en[c]);
    end

    a_r1_drivers_off: assert property (@(posedge clk)
        !rst_n |=> ((drv_pri_en == '0) && (drv_sec_en == '0) && (chan_pd == '1)));
endmodule

// File: tb/bcfg_bcast_bank_bench.sv
module bcfg_bcast_bank_bench;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = 4'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [3:0]  drv_pri_en, drv_sec_en, pll_pd, rx_rate, trn_rate, chan_pd;
    logic [7:0]  rx_mode, dsel1, dsel2, mask_rb;
    logic [31:0] st0_rb, st1_rb, dyn_rb;

    always #5 clk = ~clk;

    bcfg_bcast_bank u_bcfg_bcast_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .drv_pri_en(drv_pri_en), .drv_sec_en(drv_sec_en), .pll_pd(pll_pd),
        .rx_mode(rx_mode), .rx_rate(rx_rate), .trn_rate(trn_rate),
        .dsel1(dsel1), .dsel2(dsel2), .chan_pd(chan_pd),
        .st0_rb(st0_rb), .st1_rb(st1_rb), .dyn_rb(dyn_rb), .mask_rb(mask_rb)
    );

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sb_q[$];
    int          n_run = 0;
    int          n_fail = 0;
    logic [7:0]  m_lat [12];
    logic [7:0]  m_mask;
    bit          done = 0;

    function automatic logic [31:0] actual(int kind, int idx);
        case (kind)
            0:  return 32'((idx % 3 == 0) ? st0_rb[(idx/3)*8 +: 8] :
                           (idx % 3 == 1) ? st1_rb[(idx/3)*8 +: 8] : dyn_rb[(idx/3)*8 +: 8]);
            1:  return 32'(mask_rb);
            2:  return 32'(drv_pri_en);
            3:  return 32'(drv_sec_en);
            4:  return 32'(pll_pd);
            5:  return 32'(rx_mode);
            6:  return 32'(rx_rate);
            7:  return 32'(trn_rate);
            8:  return 32'(dsel1);
            9:  return 32'(dsel2);
            default: return 32'(chan_pd);
        endcase
    endfunction

    function automatic void push(int kind, int idx, logic [31:0] exp, string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endfunction

    function automatic void push_all(string req);
        logic [3:0] pri, sec, pd, rr, tr, cpd;
        logic [7:0] md, d1, d2;
        for (int i = 0; i < 12; i++) push(0, i, 32'(m_lat[i]), req);
        push(1, 0, 32'(m_mask), req);
        for (int c = 0; c < NC; c++) begin
            pri[c] = m_lat[c*3+2][2];
            sec[c] = m_lat[c*3+2][3];
            pd[c]  = m_lat[c*3+2][6];
            md[2*c +: 2] = {m_lat[c*3+2][7], m_lat[c*3+2][5]};
            rr[c]  = m_lat[c*3][1];
            tr[c]  = m_lat[c*3+1][1];
            d1[2*c +: 2] = m_lat[c*3+1][5:4];
            d2[2*c +: 2] = m_lat[c*3+1][7:6];
            cpd[c] = !(pri[c] || sec[c]);
        end
        push(2, 0, 32'(pri), "R8");
        push(3, 0, 32'(sec), "R8");
        push(4, 0, 32'(pd), "R8");
        push(5, 0, 32'(md), "R8");
        push(6, 0, 32'(rr), "R9");
        push(7, 0, 32'(tr), "R9");
        push(8, 0, 32'(d1), "R9");
        push(9, 0, 32'(d2), "R9");
        push(10, 0, 32'(cpd), "R10");
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < NC; c++) begin
            m_lat[c*3]   = 8'hBF;
            m_lat[c*3+1] = 8'hAD;
            m_lat[c*3+2] = 8'hB3;
        end
        m_mask = 8'hFF;
    endfunction

    function automatic void model_write(logic [3:0] a, logic [7:0] d);
        logic [7:0] upd;
        if (a < 12) begin
            m_lat[a] = d;
        end else if (a < 15) begin
            upd = m_mask & 8'hFE;
            for (int c = 0; c < NC; c++) begin
                int i;
                i = c*3 + (int'(a) - 12);
                if (m_lat[i][0] || d[0])
                    m_lat[i] = (m_lat[i] & ~upd) | (d & upd);
            end
        end else begin
            m_mask = d;
        end
    endfunction

    task automatic do_reset(string req);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b1; wr_addr = 4'd2; wr_data = 8'h0C;
        @(posedge clk);
        #1;
        rst_n = 1'b1; wr_en = 1'b0;
        model_reset();
        push_all(req);
    endtask

    task automatic do_write(logic [3:0] a, logic [7:0] d, string req);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        model_write(a, d);
        push_all(req);
    endtask

    task automatic do_idle(logic [3:0] a, logic [7:0] d, string req);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1;
        push_all(req);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = actual(it.kind, it.idx);
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : driver
        model_reset();
        repeat (2) @(posedge clk);
        do_reset("R1");
        do_write(4'd5,  8'h0D, "R2");
        do_write(4'd8,  8'hB2, "R2");
        do_write(4'd14, 8'h84, "R4");
        do_write(4'd14, 8'h45, "R5");
        do_write(4'd15, 8'h0C, "R7");
        do_write(4'd14, 8'h00, "R6");
        do_write(4'd12, 8'hFE, "R6");
        do_write(4'd3,  8'h52, "R7");
        do_write(4'd15, 8'hFF, "R7");
        do_write(4'd13, 8'h73, "R5");
        do_write(4'd0,  8'h03, "R2");
        do_write(4'd11, 8'hE9, "R2");
        do_idle(4'd11, 8'h00, "R3");
        do_idle(4'd14, 8'hFF, "R3");
        do_idle(4'd15, 8'h00, "R3");
        do_write(4'd14, 8'hA0, "R4");
        do_write(4'd1,  8'h00, "R2");
        do_write(4'd13, 8'hC2, "R4");
        do_reset("R1");
        do_write(4'd14, 8'h2D, "R8");
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule